// File: doc/BRIEF.md
# Range-Matched Fully Associative TLB

A small, fully associative address translation buffer. Each slot holds an inclusive virtual range (a first and a last address), a physical page number, a valid flag and a protection word. A lookup is combinational. It scans the slots from index 0 upward and reports the first slot whose range contains the lookup address. The buffer does not judge whether an access is allowed: the consumer evaluates permissions and treats a covering slot that is not valid as a miss.

Software fills a slot in two steps on a single-cycle command port. An address command claims a slot and sets its page range and physical page. A protection command then loads the protection fields and marks the slot valid. Purges remove one covering slot or the whole buffer. When no slot already covers the page, the address command takes the slot named by a round-robin pointer. The defaults are 16 slots, 4 KiB pages and 32-bit addresses.

Top module: `tlb_range`

## Requirements
- R1: `lk_hit` is high when some live slot's range contains `lk_addr`. `lk_idx` is then the lowest such slot index. `lk_valid` is high only when `lk_hit` is high and that slot is valid.
- R2: On a hit, `lk_pa` is the slot's physical page number followed by `lk_addr[11:0]`. `lk_prot` returns the slot's protection word in the bit positions of the protection command's data (bits 29:1), with bit 0 reading as 0.
- R3: Insert-address (`cmd_op`=1) sets the chosen slot's range from the page base of `cmd_addr` (offset bits cleared) through that base plus 4095. It loads the physical page number from `cmd_data[24:5]`, clears the protection word and leaves the slot invalid.
- R4: Insert-address first clears every valid slot covering `cmd_addr`. If any slot covers it, the lowest covering slot is reused and the round-robin pointer does not move.
- R5: When no slot covers `cmd_addr`, insert-address uses the slot at the round-robin pointer. The pointer then advances by one and wraps from 15 to 0.
- R6: Insert-protection (`cmd_op`=2) picks the lowest slot covering `cmd_addr`. It stores `cmd_data[29:1]` into that slot's protection word and sets the slot valid.
- R7: Insert-protection with no covering slot changes nothing. `err_o` is high for exactly the cycle after that command, and is low at all other times.
- R8: Purge-address (`cmd_op`=3) clears the lowest covering slot only if it is valid. A covering slot that is still invalid keeps its range.
- R9: Purge-all (`cmd_op`=4) clears every slot and leaves the pointer unchanged. A cleared slot matches no address, including all ones.
- R10: Synchronous reset clears every slot and sets the round-robin pointer to 0.
- R11: `cmd_op` values 0, 5, 6 and 7 leave every slot and the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 3 | Command opcode (0 idle, 1 insert-address, 2 insert-protection, 3 purge-address, 4 purge-all) |
| cmd_addr | input | 32 | Virtual address of the command |
| cmd_data | input | 32 | Data word (physical page or protection fields) |
| lk_addr | input | 32 | Lookup virtual address |
| lk_hit | output | 1 | Some slot covers `lk_addr` |
| lk_idx | output | 4 | Index of the first covering slot |
| lk_valid | output | 1 | The covering slot is valid |
| lk_pa | output | 32 | Translated physical address |
| lk_prot | output | 30 | Protection word of the covering slot |
| err_o | output | 1 | Pulse: insert-protection found no covering slot |

## Verification
Several properties are checked on every cycle at the same address:
- a slot is covering but invalid right after insert-address;
- after insert-protection succeeds, the slot is valid and returns the written protection word;
- after a purge-address, no valid slot remains at that address;
- after purge-all, nothing hits;
- `err_o` is raised only after an insert-protection command.

Some behaviours need the bench's scenarios and its slot-by-slot model:
- which slot the round-robin pointer picks, including the wrap;
- that a re-inserted page reuses its old slot and holds the pointer;
- that reset returns the pointer to 0;
- that undefined opcodes change nothing.

// File: rtl/tlb_range.sv
module tlb_range #(
  parameter int N_ENT = 16,
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int PG_W  = 12
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               cmd_op,
  input  logic [VA_W-1:0]          cmd_addr,
  input  logic [31:0]              cmd_data,
  input  logic [VA_W-1:0]          lk_addr,
  output logic                     lk_hit,
  output logic [$clog2(N_ENT)-1:0] lk_idx,
  output logic                     lk_valid,
  output logic [PA_W-1:0]          lk_pa,
  output logic [29:0]              lk_prot,
  output logic                     err_o
);
  localparam int IDX_W = $clog2(N_ENT);
  localparam int PPN_W = PA_W - PG_W;
  localparam logic [2:0] OP_INS_ADDR = 3'd1;
  localparam logic [2:0] OP_INS_PROT = 3'd2;
  localparam logic [2:0] OP_PURGE    = 3'd3;
  localparam logic [2:0] OP_PURGE_ALL = 3'd4;

  logic [VA_W-1:0]  beg_q [N_ENT];
  logic [VA_W-1:0]  fin_q [N_ENT];
  logic [PPN_W-1:0] ppn_q [N_ENT];
  logic [28:0]      prot_q[N_ENT];
  logic [N_ENT-1:0] vld_q;
  logic [IDX_W-1:0] rr_q;

  logic [N_ENT-1:0] lk_cov, cm_cov;
  logic             cm_hit;
  logic [IDX_W-1:0] cm_idx;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign lk_cov[g] = (beg_q[g] <= lk_addr)  && (lk_addr  <= fin_q[g]);
    assign cm_cov[g] = (beg_q[g] <= cmd_addr) && (cmd_addr <= fin_q[g]);
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_idx = '0;
    cm_hit = 1'b0;
    cm_idx = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (lk_cov[i]) begin
        lk_hit = 1'b1;
        lk_idx = IDX_W'(i);
      end
      if (cm_cov[i]) begin
        cm_hit = 1'b1;
        cm_idx = IDX_W'(i);
      end
    end
  end

  assign lk_valid = lk_hit & vld_q[lk_idx];
  assign lk_pa    = {ppn_q[lk_idx], lk_addr[PG_W-1:0]};
  assign lk_prot  = {prot_q[lk_idx], 1'b0};

  wire [IDX_W-1:0] ins_idx  = cm_hit ? cm_idx : rr_q;
  wire [VA_W-1:0]  pg_base  = {cmd_addr[VA_W-1:PG_W], {PG_W{1'b0}}};
  wire [VA_W-1:0]  pg_last  = {cmd_addr[VA_W-1:PG_W], {PG_W{1'b1}}};
  wire [IDX_W-1:0] rr_next  = (rr_q == IDX_W'(N_ENT - 1)) ? '0 : rr_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_ENT; i++) begin
        beg_q[i]  <= '1;
        fin_q[i]  <= '0;
        ppn_q[i]  <= '0;
        prot_q[i] <= '0;
      end
      vld_q <= '0;
      rr_q  <= '0;
      err_o <= 1'b0;
    end else begin
      err_o <= 1'b0;
      case (cmd_op)
        OP_INS_ADDR: begin
          for (int i = 0; i < N_ENT; i++) begin
            if (cm_cov[i] && vld_q[i]) begin
              beg_q[i]  <= '1;
              fin_q[i]  <= '0;
              ppn_q[i]  <= '0;
              prot_q[i] <= '0;
              vld_q[i]  <= 1'b0;
            end
          end
          beg_q[ins_idx]  <= pg_base;
          fin_q[ins_idx]  <= pg_last;
          ppn_q[ins_idx]  <= cmd_data[5 +: PPN_W];
          prot_q[ins_idx] <= '0;
          vld_q[ins_idx]  <= 1'b0;
          if (!cm_hit) rr_q <= rr_next;
        end
        OP_INS_PROT: begin
          if (cm_hit) begin
            prot_q[cm_idx] <= cmd_data[29:1];
            vld_q[cm_idx]  <= 1'b1;
          end else begin
            err_o <= 1'b1;
          end
        end
        OP_PURGE: begin
          if (cm_hit && vld_q[cm_idx]) begin
            beg_q[cm_idx]  <= '1;
            fin_q[cm_idx]  <= '0;
            ppn_q[cm_idx]  <= '0;
            prot_q[cm_idx] <= '0;
            vld_q[cm_idx]  <= 1'b0;
          end
        end
        OP_PURGE_ALL: begin
          for (int i = 0; i < N_ENT; i++) begin
            beg_q[i]  <= '1;
            fin_q[i]  <= '0;
            ppn_q[i]  <= '0;
            prot_q[i] <= '0;
          end
          vld_q <= '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/tlb_range_chk.sv
module tlb_range_chk #(
  parameter int VA_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [2:0]      cmd_op,
  input logic [VA_W-1:0] cmd_addr,
  input logic [31:0]     cmd_data,
  input logic [VA_W-1:0] lk_addr,
  input logic            lk_hit,
  input logic            lk_valid,
  input logic [29:0]     lk_prot,
  input logic            err_o
);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  a_r3_fresh_invalid: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cmd_op) == 3'd1 && lk_addr == $past(cmd_addr)) |-> (lk_hit && !lk_valid));

  a_r6_prot_loaded: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cmd_op) == 3'd2 && !err_o && lk_addr == $past(cmd_addr))
      |-> (lk_valid && lk_prot == {$past(cmd_data[29:1]), 1'b0}));

  a_r7_err_source: assert property (@(posedge clk) disable iff (rst)
    err_o |-> (armed && $past(cmd_op) == 3'd2));

  a_r8_purged_invalid: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cmd_op) == 3'd3 && lk_addr == $past(cmd_addr)) |-> !lk_valid);

  a_r9_all_gone: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(cmd_op) == 3'd4) |-> !lk_hit);
endmodule

bind tlb_range tlb_range_chk #(.VA_W(VA_W)) u_chk (
  .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
  .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_valid(lk_valid), .lk_prot(lk_prot), .err_o(err_o)
);

// File: tb/sim_tlb_range.sv
`timescale 1ns/1ps
module sim_tlb_range;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cmd_op = '0;
  logic [31:0] cmd_addr = '0, cmd_data = '0, lk_addr = '0;
  logic        lk_hit, lk_valid, err_o;
  logic [3:0]  lk_idx;
  logic [31:0] lk_pa;
  logic [29:0] lk_prot;

  always #2 clk = ~clk;

  tlb_range u0 (.*);

  int errors = 0, checks = 0;

  // reference model: per-slot state, behavioural
  bit        m_live[16];
  bit        m_vld[16];
  bit [19:0] m_pg[16];
  bit [19:0] m_ppn[16];
  bit [29:0] m_prot[16];
  int        m_rr = 0;
  bit        m_err = 0;

  function automatic int find(bit [31:0] a);
    for (int i = 0; i < 16; i++) if (m_live[i] && m_pg[i] == a[31:12]) return i;
    return -1;
  endfunction

  function automatic void wipe(int i);
    m_live[i] = 0; m_vld[i] = 0; m_pg[i] = 0; m_ppn[i] = 0; m_prot[i] = 0;
  endfunction

  always @(posedge clk) begin
    int f;
    m_err = 0;
    if (rst) begin
      for (int i = 0; i < 16; i++) wipe(i);
      m_rr = 0;                                    // R10
    end else begin
      f = find(cmd_addr);
      case (cmd_op)
        3'd1: begin
          for (int i = 0; i < 16; i++)
            if (m_live[i] && m_vld[i] && m_pg[i] == cmd_addr[31:12]) wipe(i);
          if (f < 0) begin f = m_rr; m_rr = (m_rr + 1) % 16; end
          m_live[f] = 1; m_vld[f] = 0; m_pg[f] = cmd_addr[31:12];
          m_ppn[f] = cmd_data[24:5]; m_prot[f] = 0;
        end
        3'd2: if (f >= 0) begin m_prot[f] = {cmd_data[29:1], 1'b0}; m_vld[f] = 1; end
              else m_err = 1;
        3'd3: if (f >= 0 && m_vld[f]) wipe(f);
        3'd4: for (int i = 0; i < 16; i++) wipe(i);
        default: ;
      endcase
    end
  end

  task automatic chk(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h @%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    int f = find(lk_addr);
    chk("R1", "hit", lk_hit, f >= 0);
    chk("R7", "err", err_o, m_err);
    if (f >= 0) begin
      chk("R1", "idx", lk_idx, f);
      chk("R6", "valid", lk_valid, m_vld[f]);
      chk("R2", "pa", lk_pa, {m_ppn[f], lk_addr[11:0]});
      chk("R2", "prot", lk_prot, m_prot[f]);
    end else chk("R1", "valid", lk_valid, 0);
  endtask

  task automatic step(input bit [2:0] op, input bit [31:0] a, input bit [31:0] d, input bit [31:0] la);
    @(negedge clk);
    compare();
    cmd_op = op; cmd_addr = a; cmd_data = d; lk_addr = la;
  endtask

  task automatic look(input bit [31:0] la);
    step(3'd0, 32'h0, 32'h0, la);
  endtask

  function automatic bit [31:0] pgaddr(int n);
    return 32'h2000_0000 + (n << 12);
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: empty after reset
    look(32'h0); look(32'hFFFF_FFFF);
    // R3: insert-address leaves an invalid covering slot
    step(3'd1, 32'h1000_0123, 32'hABCDE << 5, 32'h1000_0FFF);
    look(32'h1000_0000); look(32'h1000_1000); look(32'h0FFF_FFFF);
    // R6: protection load sets valid; R2 field layout
    step(3'd2, 32'h1000_0456, 32'h3FFF_FFFF, 32'h1000_0ABC);
    look(32'h1000_0ABC);
    // R5: 16 fresh pages wrap the pointer and evict slot 0
    for (int n = 1; n <= 16; n++) begin
      step(3'd1, pgaddr(n), (n * 32'h111) << 5, pgaddr(n) + 4);
      step(3'd2, pgaddr(n), n << 1, pgaddr(n) + 8);
    end
    look(32'h1000_0ABC);
    for (int n = 1; n <= 16; n++) look(pgaddr(n) + n);
    // R4: re-insert a valid page: same slot, pointer held
    step(3'd1, pgaddr(5) + 12, 32'h55555 << 5, pgaddr(5));
    look(pgaddr(5));
    step(3'd1, 32'h3000_0000, 32'h1 << 5, 32'h3000_0000);   // goes to pointer slot
    look(32'h3000_0000); look(pgaddr(1));
    // R7: protection with no covering slot
    step(3'd2, 32'h4000_0000, 32'h2AAA_AAAA, 32'h4000_0000);
    look(32'h4000_0000); look(32'h3000_0000);
    // R8: purge valid page; purge of invalid page is ignored
    step(3'd3, pgaddr(7), 0, pgaddr(7));
    look(pgaddr(7));
    step(3'd3, pgaddr(5) + 1, 0, pgaddr(5));
    look(pgaddr(5)); look(32'h3000_0000);
    // R11: undefined opcodes and idle do nothing
    for (int op = 5; op <= 7; op++) step(3'(op), pgaddr(9), 32'hFFFF_FFFF, pgaddr(9));
    step(3'd0, pgaddr(10), 32'hFFFF_FFFF, pgaddr(10));
    look(pgaddr(9)); look(pgaddr(10));
    // R9: purge-all, all-ones address never hits, pointer unchanged
    step(3'd4, 32'h0, 32'h0, 32'hFFFF_FFFF);
    look(pgaddr(3)); look(32'hFFFF_FFFF);
    step(3'd1, 32'h5000_0000, 32'h7 << 5, 32'h5000_0000);
    look(32'h5000_0000);
    // R10: reset mid-run returns pointer to 0
    @(negedge clk); compare(); rst = 1'b1; cmd_op = 0;
    @(negedge clk); compare(); rst = 1'b0;
    look(32'h5000_0000);
    step(3'd1, 32'h6000_0000, 32'h9 << 5, 32'h6000_0000);
    look(32'h6000_0000);
    look(32'h6000_0000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule